// File: doc/BRIEF.md
# Periodic Conversion Pacing Timer

This block paces periodic analog sampling. The input clock first passes through a two-stage divider. The first stage divides by twice a programmable field, and the second stage divides by a power of two. Each divided tick advances a 16-bit time-base counter. The counter either climbs from zero to the period and wraps, or climbs to the period and then descends back to zero.

Each time the counter takes a new value, the block compares it against a chosen event: reaching zero, reaching the period, or matching the compare value while rising or while falling. Qualifying events pass through an event-count prescaler. The block then issues a one-cycle start-of-conversion strobe on every first, second or third event. The strobe is issued only while the trigger enable is set.

Period and compare values are held in shadow registers. They reload only while the counter sits at zero, so a cycle that has already started always runs to its end.

Top module: `conv_pacer`

## Requirements
- R1: The counter advances once every D input clocks, where D = (hs_div_i == 0 ? 1 : 2*hs_div_i) * 2^ck_div_i. For example, hs_div_i=3 with ck_div_i=0 gives D=6.
- R2: With cnt_mode_i=0 (up-count), the counter runs 0..period and wraps, so any event repeats every (period+1)*D input clocks.
- R3: With cnt_mode_i=1 (up-down), the counter rises to period and falls back to 0, so any event repeats every 2*period*D input clocks.
- R4: evt_sel_i selects the event. 1 is counter at zero, 2 is counter at period, 4 is compare match while rising, and 5 is compare match while falling. Every other code selects no event. In up-count mode every value is reached while rising, so code 5 never fires.
- R5: evt_ps_i = N (1..3) issues a strobe on every N-th qualifying event, after which the event count clears. N=0 issues no strobe.
- R6: No strobe is issued while trig_en_i is 0.
- R7: Each strobe is high for exactly one input-clock cycle.
- R8: period_i and compare_i take effect only while the counter is at zero. A change made mid-cycle lets the current cycle complete with the old period.
- R9: While rst_n is low the strobe is 0. After release the counter restarts from 0. With D=1 and compare match while rising on compare value C, the first strobe is seen C+2 cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode_i | input | 1 | 0 = up-count, 1 = up-down |
| hs_div_i | input | 3 | First divider stage field (divide by 2x, 0 means 1) |
| ck_div_i | input | 3 | Power-of-two divider exponent |
| period_i | input | 16 | Counter period (shadowed) |
| compare_i | input | 16 | Compare value (shadowed) |
| evt_sel_i | input | 3 | Event select code |
| evt_ps_i | input | 2 | Events per strobe (0 = off) |
| trig_en_i | input | 1 | Trigger enable |
| soc_o | output | 1 | Start-of-conversion strobe |

## Verification
The sweep crosses both counter modes with both divider stages, all four event codes and two event-prescale settings. Strobe intervals are compared against the arithmetic period, which exposes an off-by-one in the wrap, a missed turnaround in up-down mode, or a falling-edge compare that fires in up-count mode. Unused event codes, a zero event prescale and a cleared enable must stay silent over a long window, where a design with loose decoding would strobe. A period change is made just after a zero crossing. A design that reloads the period immediately would shorten the running cycle instead of finishing it.

// File: rtl/conv_pacer_pkg.sv
package conv_pacer_pkg;

  typedef enum logic {
    CM_UP     = 1'b0,
    CM_UPDOWN = 1'b1
  } cnt_mode_e;

  localparam int EV_W = 3;
  localparam logic [EV_W-1:0] EV_ZERO   = 3'd1;
  localparam logic [EV_W-1:0] EV_PERIOD = 3'd2;
  localparam logic [EV_W-1:0] EV_CMP_UP = 3'd4;
  localparam logic [EV_W-1:0] EV_CMP_DN = 3'd5;

  // Input clocks per counter tick.
  function automatic int unsigned div_ratio(int unsigned hs, int unsigned ck);
    int unsigned first;
    first = (hs == 0) ? 1 : 2 * hs;
    return first << ck;
  endfunction

  // Largest ratio reachable with the given field widths.
  function automatic int unsigned max_ratio(int unsigned hs_w, int unsigned ck_w);
    return div_ratio((1 << hs_w) - 1, (1 << ck_w) - 1);
  endfunction

endpackage

// File: rtl/cp_clk_prescale.sv
module cp_clk_prescale
  import conv_pacer_pkg::*;
#(
  parameter int HS_W = 3,
  parameter int CK_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HS_W-1:0] hs_div,
  input  logic [CK_W-1:0] ck_div,
  output logic            tick
);
  localparam int unsigned MAXR = max_ratio(HS_W, CK_W);
  localparam int DW = $clog2(MAXR + 1);

  logic [DW-1:0] div_q;
  logic [DW-1:0] limit;

  assign limit = DW'(div_ratio(32'(hs_div), 32'(ck_div)) - 1);
  assign tick  = (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cp_timebase.sv
module cp_timebase
  import conv_pacer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cmp_act,
  output logic             arr_up,
  output logic             step
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             up_nxt;

  always_comb begin
    cnt_nxt = cnt;
    up_nxt  = arr_up;
    if (mode == CM_UP) begin
      up_nxt  = 1'b1;
      cnt_nxt = (cnt >= prd_act) ? '0 : cnt + 1'b1;
    end else if (prd_act == '0) begin
      up_nxt  = 1'b0;
      cnt_nxt = '0;
    end else if ((arr_up && cnt < prd_act) || cnt == '0) begin
      up_nxt  = 1'b1;
      cnt_nxt = cnt + 1'b1;
    end else begin
      up_nxt  = 1'b0;
      cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      arr_up <= 1'b0;
      step   <= 1'b0;
    end else begin
      step <= tick;
      if (tick) begin
        cnt    <= cnt_nxt;
        arr_up <= up_nxt;
      end
    end
  end

  // Shadow reload only while the counter rests at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_act <= '0;
      cmp_act <= '0;
    end else if (cnt == '0) begin
      prd_act <= period_i;
      cmp_act <= compare_i;
    end
  end
endmodule

// File: rtl/cp_event_sel.sv
module cp_event_sel
  import conv_pacer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prd_act,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             arr_up,
  input  logic [EV_W-1:0]  sel,
  output logic             hit
);
  logic cond;

  always_comb begin
    unique case (sel)
      EV_ZERO:   cond = (cnt == '0);
      EV_PERIOD: cond = (cnt == prd_act);
      EV_CMP_UP: cond = (cnt == cmp_act) && arr_up;
      EV_CMP_DN: cond = (cnt == cmp_act) && !arr_up;
      default:   cond = 1'b0;
    endcase
  end

  assign hit = step && cond;
endmodule

// File: rtl/cp_strobe.sv
module cp_strobe #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            en,
  input  logic [PS_W-1:0] ps_sel,
  output logic            soc
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_nxt;

  assign ps_nxt = ps_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
      soc  <= 1'b0;
    end else if (ps_sel == '0) begin
      ps_q <= '0;
      soc  <= 1'b0;
    end else if (hit && en) begin
      if (ps_nxt == ps_sel) begin
        ps_q <= '0;
        soc  <= 1'b1;
      end else begin
        ps_q <= ps_nxt;
        soc  <= 1'b0;
      end
    end else begin
      soc <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_pacer.sv
module conv_pacer
  import conv_pacer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HS_W  = 3,
  parameter int CK_W  = 3,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_mode_i,
  input  logic [HS_W-1:0]  hs_div_i,
  input  logic [CK_W-1:0]  ck_div_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic [EV_W-1:0]  evt_sel_i,
  input  logic [PS_W-1:0]  evt_ps_i,
  input  logic             trig_en_i,
  output logic             soc_o
);
  // Named internal events, also observed by the bound checker.
  logic             tick_w;
  logic             step_w;
  logic             arr_up_w;
  logic             hit_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] prd_act_w;
  logic [CNT_W-1:0] cmp_act_w;

  cp_clk_prescale #(.HS_W(HS_W), .CK_W(CK_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .hs_div(hs_div_i), .ck_div(ck_div_i), .tick(tick_w)
  );

  cp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .mode(cnt_mode_e'(cnt_mode_i)),
    .period_i(period_i), .compare_i(compare_i), .cnt(cnt_w),
    .prd_act(prd_act_w), .cmp_act(cmp_act_w), .arr_up(arr_up_w), .step(step_w)
  );

  cp_event_sel #(.CNT_W(CNT_W)) u_ev (
    .step(step_w), .cnt(cnt_w), .prd_act(prd_act_w), .cmp_act(cmp_act_w),
    .arr_up(arr_up_w), .sel(evt_sel_i), .hit(hit_w)
  );

  cp_strobe #(.PS_W(PS_W)) u_st (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .en(trig_en_i), .ps_sel(evt_ps_i), .soc(soc_o)
  );
endmodule

// File: rtl/conv_pacer_chk.sv
module conv_pacer_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soc,
  input logic             trig_en,
  input logic [PS_W-1:0]  ps_sel,
  input logic             tick,
  input logic             hit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd_act
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_act || cnt == '0 || $past(cnt) != '0);

  assert_ps_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> $past(ps_sel) != '0);

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> $past(trig_en));

  assert_from_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> $past(hit));

  assert_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 |=> $stable(prd_act));
endmodule

bind conv_pacer conv_pacer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .soc(soc_o), .trig_en(trig_en_i), .ps_sel(evt_ps_i),
  .tick(tick_w), .hit(hit_w), .cnt(cnt_w), .prd_act(prd_act_w)
);

// File: tb/conv_pacer_tb_top.sv
module conv_pacer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [2:0]  hs = 3'd0;
  logic [2:0]  ck = 3'd0;
  logic [15:0] prd = 16'd4;
  logic [15:0] cmp = 16'd2;
  logic [2:0]  sel = 3'd1;
  logic [1:0]  ps = 2'd1;
  logic        en = 1'b0;
  logic        soc;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  conv_pacer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_mode_i(mode), .hs_div_i(hs), .ck_div_i(ck),
    .period_i(prd), .compare_i(cmp), .evt_sel_i(sel), .evt_ps_i(ps),
    .trig_en_i(en), .soc_o(soc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycles until the next sampled high strobe, -1 on timeout.
  task automatic wait_hi(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!soc && n < lim);
    if (!soc) n = -1;
  endtask

  function automatic int expect_gap(input bit m, input int h, input int c, input int p,
                                    input int s, input int q, input bit e);
    int r;
    r = (h == 0) ? 1 : h + h;
    r = r * (1 << c);
    if (q == 0 || !e) return 0;
    if (!(s == 1 || s == 2 || s == 4 || s == 5)) return 0;
    if (!m && s == 5) return 0;
    return m ? r * 2 * p * q : r * (p + 1) * q;
  endfunction

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input bit m, input int h, input int c, input int p, input int cp,
                         input int s, input int q, input bit e, input string req);
    int exp, n, g, highs;
    bit w;
    @(negedge clk);
    mode = m; hs = 3'(h); ck = 3'(c); prd = 16'(p); cmp = 16'(cp);
    sel = 3'(s); ps = 2'(q); en = e;
    restart();
    exp = expect_gap(m, h, c, p, s, q, e);
    if (exp == 0) begin
      highs = 0;
      repeat (400) begin
        @(negedge clk);
        if (soc) highs++;
      end
      chk(highs == 0, req, highs, 0);
    end else begin
      wait_hi(4 * exp + 64, n);
      chk(n > 0, req, n, 1);
      wait_hi(4 * exp + 64, g);
      chk(g == exp, req, g, exp);
      @(negedge clk);
      w = soc;
      chk(!w, "R7 single-cycle strobe", int'(w), 0);
      wait_hi(4 * exp + 64, g);
      chk(g + 1 == exp, req, g + 1, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int hs_set[2] = '{0, 2};
    int sel_set[4] = '{1, 2, 4, 5};
    int ps_set[2] = '{1, 3};
    int n, g;

    // R9: strobe quiet in reset, restart timing from zero.
    mode = 1'b0; prd = 16'd50; cmp = 16'd10; sel = 3'd4; ps = 2'd1; en = 1'b1;
    repeat (3) @(negedge clk);
    chk(soc == 1'b0, "R9 reset strobe", int'(soc), 0);
    rst_n = 1'b1;
    wait_hi(200, n);
    chk(n == 12, "R9 first strobe after release", n, 12);

    // R1 R2 R3 R4 R5 sweep over modes, dividers, events, prescale.
    for (int m = 0; m < 2; m++)
      for (int hi = 0; hi < 2; hi++)
        for (int c = 0; c < 2; c++)
          for (int si = 0; si < 4; si++)
            for (int pi = 0; pi < 2; pi++)
              run_cfg(m[0], hs_set[hi], c, 4, 2, sel_set[si], ps_set[pi], 1'b1,
                      m ? "R3,R1,R4,R5 sweep" : "R2,R1,R4,R5 sweep");

    // R1 larger compound divide: 6*4 = 24.
    run_cfg(1'b0, 3, 2, 3, 1, 1, 2, 1'b1, "R1 compound divide");
    // R4 unused code silent.
    run_cfg(1'b1, 0, 0, 4, 2, 3, 1, 1'b1, "R4 unused code");
    // R5 prescale zero silent.
    run_cfg(1'b0, 0, 0, 4, 2, 1, 0, 1'b1, "R5 prescale off");
    // R6 enable low silent.
    run_cfg(1'b0, 0, 0, 4, 2, 1, 1, 1'b0, "R6 enable low");

    // R8 period change mid-cycle.
    @(negedge clk);
    mode = 1'b0; hs = 3'd0; ck = 3'd0; prd = 16'd20; sel = 3'd1; ps = 2'd1; en = 1'b1;
    restart();
    wait_hi(200, n);
    wait_hi(200, n);
    prd = 16'd4;
    wait_hi(200, g);
    chk(g == 21, "R8 running cycle keeps old period", g, 21);
    wait_hi(200, g);
    chk(g == 5, "R8 new period after zero", g, 5);

    // R1 R2 divide by 6, period 12499: 75000 input clocks.
    run_cfg(1'b0, 3, 0, 12499, 128, 4, 1, 1'b0, "R6 enable low long period");
    @(negedge clk);
    en = 1'b1;
    restart();
    wait_hi(2000, n);
    chk(n > 0, "R2 first strobe long period", n, 1);
    wait_hi(80000, g);
    chk(g == 75000, "R1,R2 long period", g, 75000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule